// File: doc/BRIEF.md
# Receive Idle Timeout Counter

This block watches the receive side of a serial channel and reports when the incoming character stream has gone quiet. Each time the receiver moves a finished character into its holding FIFO, the block restarts a down-counter from a 16-bit preset, which is made from a high and a low byte. If the count runs out before the next character arrives, a counter-ready flag is set. When its mask bit is also set, the flag raises an interrupt. Software uses the flag to learn that a message has ended and that characters are still waiting in a FIFO that never filled.

The counter decrements only on cycles where a counter clock-enable strobe is high. All logic runs on one system clock. A command nibble switches the block between timeout mode and plain counter mode. In timeout mode the character stream drives the counter, and the ordinary software start and stop strobes have no effect. Outside timeout mode, a start strobe runs a single countdown from the preset and a stop strobe halts it.

Top module: `rxto_idle_timer`

## Requirements
- R1: After reset, `cnt_ready` and `cnt_irq` are 0 and the block is out of timeout mode, so `rx_xfer` has no effect.
- R2: A write with `cmd_op` = 0xA enters timeout mode. One cycle later `cnt_ready` is 0, and the counter stays stopped, with no expiry however many ticks arrive, until an `rx_xfer` strobe.
- R3: In timeout mode, the first `ct_tick` after an `rx_xfer` strobe loads `{preset_hi, preset_lo}` without decrementing. For a preset N ≥ 1, `cnt_ready` rises the cycle after the N-th tick that follows that reload tick. A preset of 0 behaves as 1.
- R4: Once expired, the count stays at zero and `cnt_ready` stays 1 whatever ticks arrive, until an `rx_xfer` strobe (in timeout mode) or a command.
- R5: In timeout mode, an `rx_xfer` strobe clears `cnt_ready` in the following cycle, which withdraws `cnt_irq`, and restarts the reload sequence of R3.
- R6: In timeout mode, `sw_start` and `sw_stop` change neither `cnt_ready` nor the counting.
- R7: A write with `cmd_op` = 0xC leaves timeout mode, stops the counter and keeps `cnt_ready` at its value. After that, `rx_xfer` is ignored. Writes with any other `cmd_op` value have no effect.
- R8: Out of timeout mode, `sw_start` loads the preset at once and clears `cnt_ready`, and expiry follows after N ticks as in R3. `sw_stop` halts the counter and clears `cnt_ready`. When both strobes are high in the same cycle, stop wins.
- R9: `cnt_irq` equals `cnt_ready` AND `rdy_mask` in the same cycle (default `IRQ_REG` = 0).
- R10: A command write in the same cycle as `rx_xfer` wins, and the strobe is discarded. An `rx_xfer` in the same cycle as the tick that would expire the count wins, so `cnt_ready` stays 0 and a new reload is armed.
- R11: On cycles with `ct_tick` low and no other strobe, the count and `cnt_ready` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ct_tick | input | 1 | Counter clock enable, one cycle per count step |
| rx_xfer | input | 1 | Character moved into the receive FIFO |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 4 | Upper nibble of the written command byte |
| sw_start | input | 1 | Software counter start strobe |
| sw_stop | input | 1 | Software counter stop strobe |
| preset_hi | input | 8 | Upper byte of the count preset |
| preset_lo | input | 8 | Lower byte of the count preset |
| rdy_mask | input | 1 | Interrupt mask for the ready flag |
| cnt_ready | output | 1 | Counter-ready flag |
| cnt_irq | output | 1 | Masked counter-ready interrupt |

## Verification
Two events can land on the same clock edge: a character transfer and the tick that would drive the count to zero. A third collision is a character transfer against a command write. Directed sequences with a preset of 2 and a tick on every cycle place the strobe exactly on the expiring tick, and another sequence places a leave command on the same edge as a strobe. A long random phase with small presets and dense strobes provokes both collisions many more times. A behavioural model in the bench applies the stated priorities, and every cycle its ready and interrupt values are compared with the ports.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
   // Counter phase: stopped, reload armed, counting, expired
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ARM  = 2'd1,
      PH_RUN  = 2'd2,
      PH_DONE = 2'd3
   } rxto_phase_e;
endpackage

// File: rtl/rxto_cmd_dec.sv
module rxto_cmd_dec #(
   parameter int unsigned           OP_W     = 4,
   parameter logic [OP_W-1:0]       ENTER_OP = 'hA,
   parameter logic [OP_W-1:0]       LEAVE_OP = 'hC
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_wr,
   input  logic [OP_W-1:0] cmd_op,
   output logic            enter_p,
   output logic            leave_p,
   output logic            tmo_mode
);
   generate
      if (ENTER_OP == LEAVE_OP) begin : g_bad_ops
         $error("rxto_cmd_dec: enter and leave codes must differ");
      end
   endgenerate

   assign enter_p = cmd_wr && (cmd_op == ENTER_OP);
   assign leave_p = cmd_wr && (cmd_op == LEAVE_OP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tmo_mode <= 1'b0;
      else if (enter_p) tmo_mode <= 1'b1;
      else if (leave_p) tmo_mode <= 1'b0;
   end

   AST_MODE_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
      leave_p |=> !tmo_mode) else $error("leave command did not clear mode"); // R7
endmodule

// File: rtl/rxto_count.sv
module rxto_count #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic         dec,
   input  logic [W-1:0] preset,
   output logic [W-1:0] cnt,
   output logic         cnt_last
);
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] ZERO = '0;

   generate
      if (W < 2) begin : g_bad_w
         $error("rxto_count: width must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= ZERO;
      else if (ld)                  cnt <= preset;
      else if (dec && cnt != ZERO)  cnt <= cnt - ONE;
   end

   // A step from one or zero is the expiring step
   assign cnt_last = (cnt <= ONE);

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !dec) |=> $stable(cnt)) else $error("count moved without load or step"); // R11
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && cnt == ZERO) |=> cnt == ZERO) else $error("count wrapped below zero"); // R4
endmodule

// File: rtl/rxto_seq.sv
module rxto_seq
   import rxto_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick,
   input  logic        xfer,
   input  logic        enter_p,
   input  logic        leave_p,
   input  logic        tmo_mode,
   input  logic        sw_start,
   input  logic        sw_stop,
   input  logic        cnt_last,
   output rxto_phase_e phase,
   output logic        ld_preset,
   output logic        dec_en,
   output logic        rdy
);
   rxto_phase_e ph_n;
   logic        rdy_n;

   // Priority: mode commands, character strobe, software strobes, tick
   always_comb begin
      ph_n      = phase;
      rdy_n     = rdy;
      ld_preset = 1'b0;
      dec_en    = 1'b0;
      if (enter_p) begin
         ph_n  = PH_IDLE;
         rdy_n = 1'b0;
      end else if (leave_p) begin
         ph_n  = PH_IDLE;
      end else if (tmo_mode && xfer) begin
         ph_n  = PH_ARM;
         rdy_n = 1'b0;
      end else if (!tmo_mode && sw_stop) begin
         ph_n  = PH_IDLE;
         rdy_n = 1'b0;
      end else if (!tmo_mode && sw_start) begin
         ph_n      = PH_RUN;
         ld_preset = 1'b1;
         rdy_n     = 1'b0;
      end else if (tick) begin
         unique case (phase)
            PH_ARM: begin
               ld_preset = 1'b1;
               ph_n      = PH_RUN;
            end
            PH_RUN: begin
               dec_en = 1'b1;
               if (cnt_last) begin
                  ph_n  = PH_DONE;
                  rdy_n = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         rdy   <= 1'b0;
      end else begin
         phase <= ph_n;
         rdy   <= rdy_n;
      end
   end

   AST_SW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_mode && (sw_start || sw_stop) && !xfer && !enter_p && !leave_p && !tick)
      |=> ($stable(phase) && $stable(rdy))) else $error("software strobe acted in timeout mode"); // R6
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DONE && !xfer && !enter_p && !leave_p && !sw_start && !sw_stop)
      |=> (phase == PH_DONE && rdy)) else $error("expired state left without cause"); // R4
endmodule

// File: rtl/rxto_idle_timer.sv
module rxto_idle_timer
   import rxto_pkg::*;
#(
   parameter int unsigned PRESET_W = 16,
   parameter int unsigned OP_W     = 4,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ct_tick,
   input  logic                   rx_xfer,
   input  logic                   cmd_wr,
   input  logic [OP_W-1:0]        cmd_op,
   input  logic                   sw_start,
   input  logic                   sw_stop,
   input  logic [PRESET_W/2-1:0]  preset_hi,
   input  logic [PRESET_W/2-1:0]  preset_lo,
   input  logic                   rdy_mask,
   output logic                   cnt_ready,
   output logic                   cnt_irq
);
   localparam int unsigned HALF_W = PRESET_W / 2;
   localparam logic [OP_W-1:0] ENTER_OP = 'hA;
   localparam logic [OP_W-1:0] LEAVE_OP = 'hC;

   generate
      if ((PRESET_W % 2) != 0 || PRESET_W < 2) begin : g_bad_w
         $error("rxto_idle_timer: preset width must be even and at least 2");
      end
      if (OP_W < 4) begin : g_bad_op
         $error("rxto_idle_timer: command field too narrow for its codes");
      end
   endgenerate

   logic                enter_p, leave_p, tmo_mode;
   logic                ld_preset, dec_en, cnt_last;
   logic [PRESET_W-1:0] preset, cnt;
   rxto_phase_e         phase;

   assign preset = {preset_hi, preset_lo};

   rxto_cmd_dec #(
      .OP_W     (OP_W),
      .ENTER_OP (ENTER_OP),
      .LEAVE_OP (LEAVE_OP)
   ) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_wr),
      .cmd_op   (cmd_op),
      .enter_p  (enter_p),
      .leave_p  (leave_p),
      .tmo_mode (tmo_mode)
   );

   rxto_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (ct_tick),
      .xfer      (rx_xfer),
      .enter_p   (enter_p),
      .leave_p   (leave_p),
      .tmo_mode  (tmo_mode),
      .sw_start  (sw_start),
      .sw_stop   (sw_stop),
      .cnt_last  (cnt_last),
      .phase     (phase),
      .ld_preset (ld_preset),
      .dec_en    (dec_en),
      .rdy       (cnt_ready)
   );

   rxto_count #(.W(PRESET_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ld_preset),
      .dec      (dec_en),
      .preset   (preset),
      .cnt      (cnt),
      .cnt_last (cnt_last)
   );

   generate
      if (IRQ_REG) begin : g_irq_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_irq <= 1'b0;
            else        cnt_irq <= cnt_ready && rdy_mask;
         end
      end else begin : g_irq_comb
         assign cnt_irq = cnt_ready && rdy_mask;
      end
   endgenerate

   AST_ENTER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_op == ENTER_OP) |=> (!cnt_ready && phase == PH_IDLE))
      else $error("enter command did not clear and stop"); // R2
   AST_XFER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_mode && rx_xfer && !cmd_wr) |=> (!cnt_ready && phase == PH_ARM))
      else $error("character did not clear ready and arm"); // R5
   AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ARM && ct_tick && !rx_xfer && !cmd_wr) |=> (cnt == $past(preset)))
      else $error("reload tick did not load the preset"); // R3
   AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnt_ready) |-> (cnt == '0))
      else $error("ready rose with a nonzero count"); // R4
endmodule

// File: tb/rxto_idle_timer_bench.sv
module rxto_idle_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ct_tick = 1'b0, rx_xfer = 1'b0, cmd_wr = 1'b0;
   logic [3:0] cmd_op = 4'h0;
   logic       sw_start = 1'b0, sw_stop = 1'b0, rdy_mask = 1'b0;
   logic [7:0] preset_hi = 8'h00, preset_lo = 8'h00;
   logic       cnt_ready, cnt_irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk; // 125 MHz

   rxto_idle_timer u_rxto_idle_timer (
      .clk(clk), .rst_n(rst_n), .ct_tick(ct_tick), .rx_xfer(rx_xfer),
      .cmd_wr(cmd_wr), .cmd_op(cmd_op), .sw_start(sw_start), .sw_stop(sw_stop),
      .preset_hi(preset_hi), .preset_lo(preset_lo), .rdy_mask(rdy_mask),
      .cnt_ready(cnt_ready), .cnt_irq(cnt_irq)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference: mode flag, pending reload, running flag, count, ready
   bit m_mode, m_pend, m_run, m_rdy;
   int m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_pend = 0; m_run = 0; m_rdy = 0; m_cnt = 0;
      end else if (cmd_wr && cmd_op == 4'hA) begin
         m_mode = 1; m_pend = 0; m_run = 0; m_rdy = 0;
      end else if (cmd_wr && cmd_op == 4'hC) begin
         m_mode = 0; m_pend = 0; m_run = 0;
      end else if (m_mode && rx_xfer) begin
         m_pend = 1; m_run = 0; m_rdy = 0;
      end else if (!m_mode && sw_stop) begin
         m_pend = 0; m_run = 0; m_rdy = 0;
      end else if (!m_mode && sw_start) begin
         m_cnt = {preset_hi, preset_lo}; m_run = 1; m_pend = 0; m_rdy = 0;
      end else if (ct_tick) begin
         if (m_pend) begin
            m_cnt = {preset_hi, preset_lo}; m_pend = 0; m_run = 1;
         end else if (m_run) begin
            if (m_cnt <= 1) begin
               m_cnt = 0; m_run = 0; m_rdy = 1;
            end else m_cnt = m_cnt - 1;
         end
      end
   end

   // Every-cycle comparison after the edge has settled
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         check("R3/R4 model ready", cnt_ready, m_rdy);
         check("R9 model irq", cnt_irq, m_rdy && rdy_mask);
      end
   end

   task automatic drive(input bit t, input bit x, input bit w, input logic [3:0] op,
                        input bit st, input bit sp);
      ct_tick = t; rx_xfer = x; cmd_wr = w; cmd_op = op; sw_start = st; sw_stop = sp;
      @(negedge clk);
      ct_tick = 0; rx_xfer = 0; cmd_wr = 0; sw_start = 0; sw_stop = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(0, 0, 0, 4'h0, 0, 0);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) drive(1, 0, 0, 4'h0, 0, 0);
   endtask

   task automatic set_preset(input int v);
      preset_hi = v[15:8]; preset_lo = v[7:0];
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset ready", cnt_ready, 1'b0);
      check("R1 reset irq", cnt_irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      drive(0, 1, 0, 4'h0, 0, 0);     // R1: transfer out of timeout mode ignored
      check("R1 xfer ignored", cnt_ready, 1'b0);

      // R8: plain countdown by software start
      set_preset(5);
      drive(0, 0, 0, 4'h0, 1, 0);
      ticks(4);
      check("R8 before expiry", cnt_ready, 1'b0);
      ticks(1);
      check("R8 expiry", cnt_ready, 1'b1);
      rdy_mask = 1'b1; #1;
      check("R9 irq masked on", cnt_irq, 1'b1);
      drive(0, 0, 0, 4'h0, 0, 1);
      check("R8 stop clears", cnt_ready, 1'b0);
      drive(0, 0, 0, 4'h0, 1, 1);     // stop wins over start
      ticks(8);
      check("R8 stop wins", cnt_ready, 1'b0);

      // R2: enter timeout mode, counter held
      drive(0, 0, 0, 4'h0, 1, 0);
      ticks(5);
      check("R8 rerun expiry", cnt_ready, 1'b1);
      drive(0, 0, 1, 4'hA, 0, 0);
      check("R2 enter clears", cnt_ready, 1'b0);
      ticks(20);
      check("R2 held until char", cnt_ready, 1'b0);

      // R3 and R11: reload then sparse ticks
      set_preset(3);
      drive(0, 1, 0, 4'h0, 0, 0);
      ticks(1);                        // reload tick
      idle(4);
      check("R11 no tick holds", cnt_ready, 1'b0);
      ticks(2);
      check("R3 before expiry", cnt_ready, 1'b0);
      ticks(1);
      check("R3 expiry", cnt_ready, 1'b1);
      ticks(10);
      check("R4 stays expired", cnt_ready, 1'b1);
      rdy_mask = 1'b0; #1;
      check("R9 irq masked off", cnt_irq, 1'b0);
      rdy_mask = 1'b1;

      // R6: software strobes ignored in timeout mode
      drive(0, 0, 0, 4'h0, 0, 1);
      check("R6 stop ignored", cnt_ready, 1'b1);
      drive(0, 0, 0, 4'h0, 1, 0);
      check("R6 start ignored", cnt_ready, 1'b1);

      // R5: character withdraws ready and irq
      drive(0, 1, 0, 4'h0, 0, 0);
      check("R5 xfer clears ready", cnt_ready, 1'b0);
      check("R5 irq withdrawn", cnt_irq, 1'b0);

      // R10: character on the expiring tick
      set_preset(2);
      ticks(2);                        // reload, 2->1
      drive(1, 1, 0, 4'h0, 0, 0);
      check("R10 xfer beats expiry", cnt_ready, 1'b0);
      ticks(2);
      check("R10 rearmed not yet", cnt_ready, 1'b0);
      ticks(1);
      check("R3 rearmed expiry", cnt_ready, 1'b1);

      // R10/R7: leave command on the same edge as a character
      drive(0, 1, 1, 4'hC, 0, 0);
      check("R10 command beats xfer", cnt_ready, 1'b1);
      drive(0, 1, 0, 4'h0, 0, 0);
      check("R7 xfer ignored after leave", cnt_ready, 1'b1);

      // R3: preset zero acts as one; R7: other opcodes ignored
      drive(0, 0, 1, 4'hA, 0, 0);
      set_preset(0);
      drive(0, 1, 0, 4'h0, 0, 0);
      ticks(1);
      check("R3 zero preset pending", cnt_ready, 1'b0);
      ticks(1);
      check("R3 zero preset expiry", cnt_ready, 1'b1);
      drive(0, 0, 1, 4'h5, 0, 0);
      check("R7 other opcode ignored", cnt_ready, 1'b1);

      // Random phase against the model
      for (int i = 0; i < 4000; i++) begin
         if (($urandom % 64) == 0) set_preset($urandom % 7);
         rdy_mask = ($urandom % 4) != 0;
         drive(($urandom % 3) == 0, ($urandom % 9) == 0, ($urandom % 40) == 0,
               (($urandom % 3) == 0) ? 4'hA : ((($urandom % 2) == 0) ? 4'hC : 4'h5),
               ($urandom % 15) == 0, ($urandom % 20) == 0);
      end
      idle(2);
      finish_run();
   end
endmodule